// File: doc/BRIEF.md
# SDR DRAM Data Path with Programmable Read Latency

This block is the data half of a single-data-rate synchronous DRAM device model. It takes command strobes that have already been decoded (read, write, precharge, burst stop), the data mask pin, and the word the cell array supplies for each read beat. From these it builds the 4-bit data bus behaviour. Read words reach the bus a programmable 2 or 3 cycles after the beat that fetched them. Write words are taken from the bus on the cycle of the write beat itself.

Each read or write command opens a burst whose length comes from a configuration code. A burst counter issues one beat per cycle. Read beats travel through a short shift register of valid/data slots, and the slot that feeds the output register is chosen by the latency setting. The mask acts two cycles late on reads and in the same cycle on writes. A precharge or burst stop stops issuing beats. Beats already in flight still drain, so the bus goes to high impedance exactly one latency after the command. A new read replaces the old burst without a gap, and a write flushes any read data still queued.

Top module: `sdr_datapath`

## Requirements
- R1: With `lat_sel`=0 (latency 2), the array word of a read beat issued in cycle c is on `dq_out` with `dq_oe`=1 in cycle c+2.
- R2: With `lat_sel`=1 (latency 3), the array word of a read beat issued in cycle c is on `dq_out` with `dq_oe`=1 in cycle c+3.
- R3: A read command starts a burst of 2^`bl_code` beats (code 0=1, 1=2, 2=4, 3=8), one beat per consecutive cycle starting with the command cycle. `dq_oe` falls in the cycle after the last beat's data.
- R4: `dqm` high in cycle c forces `dq_oe`=0 in cycle c+2, whatever the latency. The read beat that would have been on the bus then is lost.
- R5: A write command in cycle c opens a burst of 2^`bl_code` beats. For beat k (cycle c+k), `wr_valid`=1 and `wr_data` equals the value of `dq_in` in cycle c+k, both shown in cycle c+k+1.
- R6: `dqm` high in a write beat cycle blocks that beat: `wr_valid`=0 in the following cycle.
- R7: A precharge or burst stop in cycle c issues no further read beats from cycle c on. The last read data is on the bus in cycle c+L-1 and `dq_oe`=0 from cycle c+L.
- R8: A read command during a read burst restarts the burst. Beats of the old burst issued before it still appear, the new data follows from c+L, and `dq_oe` stays high without a gap.
- R9: A write command in cycle c drops all queued read data: `dq_oe`=0 from cycle c+1.
- R10: When strobes coincide, write takes priority over read, and read takes priority over precharge or burst stop.
- R11: After reset, and in the first cycle after reset is released, `dq_oe`=0 and `wr_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_sel | input | 1 | Read latency select: 0 = 2 cycles, 1 = 3 cycles |
| bl_code | input | 2 | Burst length code, 2^code beats |
| rd_cmd | input | 1 | Decoded read command strobe |
| wr_cmd | input | 1 | Decoded write command strobe |
| pre_cmd | input | 1 | Decoded precharge strobe |
| stop_cmd | input | 1 | Decoded burst-stop strobe |
| dqm | input | 1 | Data mask pin |
| arr_rdata | input | 4 | Array word for the read beat issued this cycle |
| dq_in | input | 4 | Data bus as seen at the input buffer |
| dq_out | output | 4 | Data driven onto the bus |
| dq_oe | output | 1 | Output enable; 0 means high impedance |
| wr_data | output | 4 | Captured write word |
| wr_valid | output | 1 | Write word valid strobe |

## Verification
The bench works out the bus contents cycle by cycle for each latency and burst code. It checks the first and the last data cycle, because a design with one register too many or too few shifts the burst by a cycle, and a wrong burst counter leaves the bus driven too long or cuts it short. Mask timing is checked in the middle of a latency-2 burst: a mask that acts one cycle early or late blanks the wrong word, and a write mask with any delay lets the masked beat through. Precharge, burst stop and read interruption are aimed at the cycle where the old data must end. A design that flushed the pipe would cut the bus too early, and one that ignored the command would keep driving stale beats. Write-over-read and coinciding strobes expose a wrong priority order, which shows up as read data appearing on the bus during a write.

// File: rtl/sdr_dp_pkg.sv
`timescale 1ns/1ps
package sdr_dp_pkg;

    typedef enum logic [1:0] {
        BM_IDLE  = 2'd0,
        BM_READ  = 2'd1,
        BM_WRITE = 2'd2
    } burst_mode_e;

endpackage

// File: rtl/sdr_dp_burst.sv
`timescale 1ns/1ps
module sdr_dp_burst
    import sdr_dp_pkg::*;
#(
    parameter int BLC_W = 2,
    parameter int REM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLC_W-1:0] bl_code,
    input  logic             rd_cmd,
    input  logic             wr_cmd,
    input  logic             pre_cmd,
    input  logic             stop_cmd,
    output logic             rd_beat,
    output logic             wr_beat,
    output logic             rd_flush
);

    typedef struct packed {
        burst_mode_e      mode;
        logic [REM_W-1:0] rem;
    } burst_st_t;

    burst_st_t st_d, st_q;
    logic [REM_W-1:0] load_v;

    always_comb begin
        // beats left after the command beat: 2^code - 1
        load_v   = REM_W'((32'd1 << bl_code) - 32'd1);
        st_d     = st_q;
        rd_beat  = 1'b0;
        wr_beat  = 1'b0;
        rd_flush = 1'b0;
        if (wr_cmd) begin
            wr_beat   = 1'b1;
            rd_flush  = 1'b1;
            st_d.rem  = load_v;
            st_d.mode = (load_v != '0) ? BM_WRITE : BM_IDLE;
        end else if (rd_cmd) begin
            rd_beat   = 1'b1;
            st_d.rem  = load_v;
            st_d.mode = (load_v != '0) ? BM_READ : BM_IDLE;
        end else if (pre_cmd || stop_cmd) begin
            st_d.rem  = '0;
            st_d.mode = BM_IDLE;
        end else if (st_q.mode != BM_IDLE && st_q.rem != '0) begin
            rd_beat  = (st_q.mode == BM_READ);
            wr_beat  = (st_q.mode == BM_WRITE);
            st_d.rem = st_q.rem - 1'b1;
            if (st_q.rem == REM_W'(1)) begin
                st_d.mode = BM_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: BM_IDLE, rem: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/sdr_dp_rd_pipe.sv
`timescale 1ns/1ps
module sdr_dp_rd_pipe #(
    parameter int DQ_W    = 4,
    parameter int MIN_LAT = 2,
    parameter int MAX_LAT = 3,
    parameter int LSEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LSEL_W-1:0] lat_sel,
    input  logic              rd_beat,
    input  logic              rd_flush,
    input  logic              dqm,
    input  logic [DQ_W-1:0]   arr_rdata,
    output logic              dq_oe,
    output logic [DQ_W-1:0]   dq_out
);

    // one slot per cycle of latency beyond the output register
    localparam int NSLOT    = MAX_LAT - 1;
    localparam int TAP_BASE = MIN_LAT - 2;

    typedef struct packed {
        logic            valid;
        logic [DQ_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [NSLOT-1:0] slot;
        logic              mask;
        logic              oe;
        logic [DQ_W-1:0]   dout;
    } pipe_st_t;

    pipe_st_t st_d, st_q;
    slot_t    tap;
    int       tap_idx;

    always_comb begin
        tap_idx = TAP_BASE + int'(lat_sel);
        tap     = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (i == tap_idx) begin
                tap = st_q.slot[i];
            end
        end

        st_d      = st_q;
        st_d.mask = dqm;
        st_d.oe   = tap.valid & ~st_q.mask;
        st_d.dout = (tap.valid & ~st_q.mask) ? tap.data : '0;

        st_d.slot[0].valid = rd_beat;
        st_d.slot[0].data  = rd_beat ? arr_rdata : '0;
        for (int i = 1; i < NSLOT; i++) begin
            st_d.slot[i] = st_q.slot[i-1];
        end

        if (rd_flush) begin
            st_d.slot = '0;
            st_d.oe   = 1'b0;
            st_d.dout = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_oe  = st_q.oe;
    assign dq_out = st_q.dout;

endmodule

// File: rtl/sdr_dp_wr_cap.sv
`timescale 1ns/1ps
module sdr_dp_wr_cap #(
    parameter int DQ_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_beat,
    input  logic            dqm,
    input  logic [DQ_W-1:0] dq_in,
    output logic            wr_valid,
    output logic [DQ_W-1:0] wr_data
);

    typedef struct packed {
        logic            valid;
        logic [DQ_W-1:0] data;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d.valid = wr_beat & ~dqm;
        st_d.data  = (wr_beat & ~dqm) ? dq_in : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.valid;
    assign wr_data  = st_q.data;

endmodule

// File: rtl/sdr_datapath.sv
`timescale 1ns/1ps
module sdr_datapath #(
    parameter int DQ_W        = 4,
    parameter int MIN_LAT     = 2,
    parameter int MAX_LAT     = 3,
    parameter int MAX_BL_CODE = 3
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic [$clog2(MAX_LAT-MIN_LAT+1)-1:0]     lat_sel,
    input  logic [$clog2(MAX_BL_CODE+1)-1:0]         bl_code,
    input  logic                                     rd_cmd,
    input  logic                                     wr_cmd,
    input  logic                                     pre_cmd,
    input  logic                                     stop_cmd,
    input  logic                                     dqm,
    input  logic [DQ_W-1:0]                          arr_rdata,
    input  logic [DQ_W-1:0]                          dq_in,
    output logic [DQ_W-1:0]                          dq_out,
    output logic                                     dq_oe,
    output logic [DQ_W-1:0]                          wr_data,
    output logic                                     wr_valid
);

    localparam int LSEL_W = $clog2(MAX_LAT-MIN_LAT+1);
    localparam int BLC_W  = $clog2(MAX_BL_CODE+1);
    localparam int REM_W  = (MAX_BL_CODE < 1) ? 1 : MAX_BL_CODE;

    logic rd_beat;
    logic wr_beat;
    logic rd_flush;

    sdr_dp_burst #(
        .BLC_W (BLC_W),
        .REM_W (REM_W)
    ) burst_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bl_code  (bl_code),
        .rd_cmd   (rd_cmd),
        .wr_cmd   (wr_cmd),
        .pre_cmd  (pre_cmd),
        .stop_cmd (stop_cmd),
        .rd_beat  (rd_beat),
        .wr_beat  (wr_beat),
        .rd_flush (rd_flush)
    );

    sdr_dp_rd_pipe #(
        .DQ_W    (DQ_W),
        .MIN_LAT (MIN_LAT),
        .MAX_LAT (MAX_LAT),
        .LSEL_W  (LSEL_W)
    ) rd_pipe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lat_sel   (lat_sel),
        .rd_beat   (rd_beat),
        .rd_flush  (rd_flush),
        .dqm       (dqm),
        .arr_rdata (arr_rdata),
        .dq_oe     (dq_oe),
        .dq_out    (dq_out)
    );

    sdr_dp_wr_cap #(
        .DQ_W (DQ_W)
    ) wr_cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_beat  (wr_beat),
        .dqm      (dqm),
        .dq_in    (dq_in),
        .wr_valid (wr_valid),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/sdr_dp_checker.sv
`timescale 1ns/1ps
module sdr_dp_checker #(
    parameter int DQ_W   = 4,
    parameter int LSEL_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LSEL_W-1:0] lat_sel,
    input logic              rd_cmd,
    input logic              wr_cmd,
    input logic              dqm,
    input logic [DQ_W-1:0]   arr_rdata,
    input logic [DQ_W-1:0]   dq_in,
    input logic [DQ_W-1:0]   dq_out,
    input logic              dq_oe,
    input logic [DQ_W-1:0]   wr_data,
    input logic              wr_valid
);

    // cycles since reset release, saturating at 3
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> (!dq_oe && !wr_valid));

    a_r1_lat2_data: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q >= 2'd2) && $past(rd_cmd && !wr_cmd, 2) && !$past(dqm, 2)
         && !$past(wr_cmd, 1) && ($past(lat_sel, 1) == LSEL_W'(0)))
        |-> (dq_oe && dq_out == $past(arr_rdata, 2)));

    a_r2_lat3_data: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd3) && $past(rd_cmd && !wr_cmd, 3) && !$past(dqm, 2)
         && !$past(wr_cmd, 2) && !$past(wr_cmd, 1)
         && ($past(lat_sel, 1) == LSEL_W'(1)))
        |-> (dq_oe && dq_out == $past(arr_rdata, 3)));

    a_r4_mask_two_late: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q >= 2'd2) && $past(dqm, 2)) |-> !dq_oe);

    a_r9_write_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q >= 2'd1) && $past(wr_cmd, 1)) |-> !dq_oe);

    a_r6_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && dqm) |=> !wr_valid);

    a_r5_write_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !dqm) |=> (wr_valid && wr_data == $past(dq_in)));

endmodule

bind sdr_datapath sdr_dp_checker #(
    .DQ_W   (DQ_W),
    .LSEL_W (LSEL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_sel   (lat_sel),
    .rd_cmd    (rd_cmd),
    .wr_cmd    (wr_cmd),
    .dqm       (dqm),
    .arr_rdata (arr_rdata),
    .dq_in     (dq_in),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid)
);

// File: tb/sdr_datapath_tb_top.sv
`timescale 1ns/1ps
module sdr_datapath_tb_top;

    localparam int NOBS = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] lat_sel = 1'b0;
    logic [1:0] bl_code = 2'd0;
    logic       rd_cmd = 1'b0, wr_cmd = 1'b0, pre_cmd = 1'b0, stop_cmd = 1'b0, dqm = 1'b0;
    logic [3:0] arr_rdata = 4'h0, dq_in = 4'h0;
    logic [3:0] dq_out, wr_data;
    logic       dq_oe, wr_valid;

    int total = 0;
    int bad   = 0;

    logic       obs_oe [NOBS];
    logic [3:0] obs_dq [NOBS];
    logic       obs_wv [NOBS];
    logic [3:0] obs_wd [NOBS];
    logic       exp_oe [NOBS];
    logic [3:0] exp_dq [NOBS];
    logic       exp_wv [NOBS];
    logic [3:0] exp_wd [NOBS];

    always #2 clk = ~clk;

    sdr_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .lat_sel(lat_sel), .bl_code(bl_code),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .pre_cmd(pre_cmd), .stop_cmd(stop_cmd),
        .dqm(dqm), .arr_rdata(arr_rdata), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .wr_data(wr_data), .wr_valid(wr_valid)
    );

    task automatic check(input string req, input int c, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", req, c, act, exp);
        end
    endtask

    task automatic clear_exp();
        for (int c = 0; c < NOBS; c++) begin
            exp_oe[c] = 1'b0; exp_dq[c] = 4'h0;
            exp_wv[c] = 1'b0; exp_wd[c] = 4'h0;
        end
    endtask

    // one command cycle n; outputs of cycle n+1 are recorded
    task automatic step(input int n, input logic r, input logic w, input logic p,
                        input logic s, input logic m, input logic [3:0] ar, input logic [3:0] di);
        rd_cmd = r; wr_cmd = w; pre_cmd = p; stop_cmd = s; dqm = m;
        arr_rdata = ar; dq_in = di;
        @(posedge clk);
        @(negedge clk);
        if (n + 1 < NOBS) begin
            obs_oe[n+1] = dq_oe; obs_dq[n+1] = dq_out;
            obs_wv[n+1] = wr_valid; obs_wd[n+1] = wr_data;
        end
    endtask

    task automatic compare(input string req);
        for (int c = 1; c < NOBS; c++) begin
            check(req, c, {3'b0, obs_oe[c]}, {3'b0, exp_oe[c]});
            if (exp_oe[c]) check(req, c, obs_dq[c], exp_dq[c]);
            check(req, c, {3'b0, obs_wv[c]}, {3'b0, exp_wv[c]});
            if (exp_wv[c]) check(req, c, obs_wd[c], exp_wd[c]);
        end
    endtask

    task automatic exp_rd(input int c, input logic [3:0] d);
        exp_oe[c] = 1'b1; exp_dq[c] = d;
    endtask

    task automatic exp_wr(input int c, input logic [3:0] d);
        exp_wv[c] = 1'b1; exp_wd[c] = d;
    endtask

    task automatic t_reset();
        check("R11", 0, {3'b0, dq_oe}, 4'h0);
        check("R11", 0, {3'b0, wr_valid}, 4'h0);
    endtask

    // R1 R3: latency 2, four beats
    task automatic t_lat2_bl4();
        lat_sel = 1'b0; bl_code = 2'd2; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, 0, 0, 0, 0, 4'h8 + 4'(n), 4'h0);
        for (int k = 0; k < 4; k++) exp_rd(2 + k, 4'h8 + 4'(k));
        compare("R1");
    endtask

    // R2 R3: latency 3, four beats
    task automatic t_lat3_bl4();
        lat_sel = 1'b1; bl_code = 2'd2; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, 0, 0, 0, 0, 4'h3 + 4'(n), 4'h0);
        for (int k = 0; k < 4; k++) exp_rd(3 + k, 4'h3 + 4'(k));
        compare("R2");
    endtask

    // R3: single beat and eight beats
    task automatic t_bl_codes();
        lat_sel = 1'b0; bl_code = 2'd0; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, 0, 0, 0, 0, 4'h5 + 4'(n), 4'h0);
        exp_rd(2, 4'h5);
        compare("R3");
        lat_sel = 1'b1; bl_code = 2'd3; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, 0, 0, 0, 0, 4'(n), 4'h0);
        for (int k = 0; k < 8; k++) exp_rd(3 + k, 4'(k));
        compare("R3");
    endtask

    // R4: mask in cycle 2 blanks cycle 4
    task automatic t_read_mask();
        lat_sel = 1'b0; bl_code = 2'd2; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, 0, 0, 0, n == 2, 4'h8 + 4'(n), 4'h0);
        exp_rd(2, 4'h8); exp_rd(3, 4'h9); exp_rd(5, 4'hB);
        compare("R4");
    endtask

    // R7: precharge at latency 3, burst stop at latency 2
    task automatic t_cutoff();
        lat_sel = 1'b1; bl_code = 2'd3; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, 0, n == 2, 0, 0, 4'(n), 4'h0);
        exp_rd(3, 4'h0); exp_rd(4, 4'h1);
        compare("R7");
        lat_sel = 1'b0; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, 0, 0, n == 3, 0, 4'h4 + 4'(n), 4'h0);
        exp_rd(2, 4'h4); exp_rd(3, 4'h5); exp_rd(4, 4'h6);
        compare("R7");
    endtask

    // R8: second read at cycle 2 continues seamlessly
    task automatic t_interrupt();
        lat_sel = 1'b0; bl_code = 2'd2; clear_exp();
        for (int n = 0; n < NOBS; n++)
            step(n, n == 0 || n == 2, 0, 0, 0, 0, (n < 2) ? 4'h1 + 4'(n) : 4'h8 + 4'(n), 4'h0);
        exp_rd(2, 4'h1); exp_rd(3, 4'h2);
        for (int k = 0; k < 4; k++) exp_rd(4 + k, 4'hA + 4'(k));
        compare("R8");
    endtask

    // R5 R6: write burst with a masked second beat
    task automatic t_write();
        bl_code = 2'd2; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, 0, n == 0, 0, 0, n == 1, 4'h0, 4'hC + 4'(n));
        exp_wr(1, 4'hC); exp_wr(3, 4'hE); exp_wr(4, 4'hF);
        compare("R6");
    endtask

    // R9: write over a latency-3 read
    task automatic t_write_over_read();
        lat_sel = 1'b1; bl_code = 2'd3; clear_exp();
        for (int n = 0; n < NOBS; n++) begin
            if (n == 2) bl_code = 2'd2;
            step(n, n == 0, n == 2, 0, 0, 0, 4'h7, 4'h2 + 4'(n));
        end
        for (int k = 0; k < 4; k++) exp_wr(3 + k, 4'h4 + 4'(k));
        compare("R9");
    endtask

    // R10: read beats precharge, write beats read
    task automatic t_priority();
        lat_sel = 1'b0; bl_code = 2'd1; clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, 0, n == 0, n == 0, 0, 4'h9 + 4'(n), 4'h0);
        exp_rd(2, 4'h9); exp_rd(3, 4'hA);
        compare("R10");
        clear_exp();
        for (int n = 0; n < NOBS; n++) step(n, n == 0, n == 0, 0, 0, 0, 4'h6, 4'h1 + 4'(n));
        exp_wr(1, 4'h1); exp_wr(2, 4'h2);
        compare("R10");
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lat2_bl4();
        t_lat3_bl4();
        t_bl_codes();
        t_read_mask();
        t_cutoff();
        t_interrupt();
        t_write();
        t_write_over_read();
        t_priority();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule